// File: doc/BRIEF.md
# Hysteretic Capacitor Bank Step Controller

This block keeps the lagging power factor of a load within a band by switching shunt capacitor sections one at a time. It takes a stream of measured power-factor angles, expressed as unsigned tenths of a degree. Each angle is compared against two reference angles that are set by parameters. By default the band runs from 14.1 degrees (power factor about 0.97) up to 18.2 degrees (power factor about 0.95). When the angle is above the upper reference, one more section is connected. When it is below the lower reference, one section is removed. Anywhere inside the band, the bank is left as it is.

The number of connected sections is held in a counter bounded to 0..SECTIONS, which is 9 by default. That counter drives a thermometer-coded enable vector, one bit per section. After each step, a settle window blocks further decisions for a run-time number of accepted samples, so that the bank cannot chatter. A request that would push the count past either end is dropped, and a one-cycle limit flag is raised instead.

The angle input is a valid/ready stream. The block never applies back-pressure: ready is high in every cycle outside reset, and a sample is consumed in any cycle where valid and ready are both high. A sample taken during the settle window is consumed but does not make a decision. Cycles with valid low have no effect.

Top module: `cap_step_ctrl`

## Requirements
- R1: A synchronous reset clears the section count to 0, drives all enables low, clears the settle window and drops the limit flag.
- R2: An accepted sample with angle greater than UPPER_REF (default 182), taken while no settle window is open and with count below SECTIONS, raises the count by one at that clock edge.
- R3: An accepted sample with angle less than LOWER_REF (default 141), taken while no settle window is open and with count above 0, lowers the count by one.
- R4: An angle in the closed range LOWER_REF..UPPER_REF leaves the count unchanged. Both boundary values count as inside the band.
- R5: A connect request at count SECTIONS, or a disconnect request at count 0, leaves the count unchanged. It sets limit_hit high for exactly the following cycle. In every other case limit_hit is low.
- R6: Bit i of sec_en is high exactly when i is less than the count, so the lowest-index sections switch in first and switch out last.
- R7: A step loads the settle window from settle_len. The next settle_len accepted samples change nothing, and settle_busy is high while any of them remain. When settle_len is 0, the very next sample decides.
- R8: A cycle with ang_valid low changes neither the count nor the settle window.
- R9: The count changes by at most one per clock, and only at an edge where a sample is accepted.
- R10: ang_ready is high in every cycle in which rst is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ang_valid | input | 1 | Angle sample valid |
| ang_ready | output | 1 | High outside reset; sample accepted when valid and ready |
| angle | input | ANGLE_W (12) | Lagging power-factor angle, tenths of a degree |
| settle_len | input | SETTLE_W (8) | Number of accepted samples blocked after each step |
| sec_count | output | CNT_W (4) | Number of sections connected |
| sec_en | output | SECTIONS (9) | Thermometer-coded section enables |
| settle_busy | output | 1 | Settle window open |
| limit_hit | output | 1 | One-cycle pulse after a request dropped at a bound |

## Verification
Directed sequences are applied first. A run of high angles with no settle window fills the bank to nine sections, and a further high angle then shows that the top request is dropped and the limit flag is pulsed. Angles of exactly 182 and 141 show that both boundaries are treated as inside the band. A run of low angles empties the bank and tests the bottom limit. A settle length of two, mixed with idle cycles, shows which samples are blocked and that idle cycles do not shorten the window. After these, a seeded random mix of in-band and out-of-band angles, gaps in valid and settle lengths from 0 to 3 is compared cycle by cycle with a bench model. This random run separates errors in step direction, in counting the settle window and in saturation.

// File: rtl/cap_step_pkg.sv
package cap_step_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_UP   = 2'd1,
    DEC_DOWN = 2'd2
  } dec_e;
endpackage

// File: rtl/cbk_decide.sv
module cbk_decide
  import cap_step_pkg::*;
#(
  parameter int ANGLE_W   = 12,
  parameter int UPPER_REF = 182,
  parameter int LOWER_REF = 141
) (
  input  logic [ANGLE_W-1:0] angle,
  output dec_e               dec
);
  localparam logic [ANGLE_W-1:0] UP_LIM = ANGLE_W'(UPPER_REF);
  localparam logic [ANGLE_W-1:0] LO_LIM = ANGLE_W'(LOWER_REF);

  always_comb begin
    if (angle > UP_LIM)      dec = DEC_UP;
    else if (angle < LO_LIM) dec = DEC_DOWN;
    else                     dec = DEC_HOLD;
  end
endmodule

// File: rtl/cbk_settle.sv
module cbk_settle #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  input  logic                tick,
  output logic                busy
);
  logic [SETTLE_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                        remain <= '0;
    else if (load)                  remain <= load_val;
    else if (tick && remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/cbk_bank.sv
module cbk_bank #(
  parameter int SECTIONS = 9,
  parameter int CNT_W    = $clog2(SECTIONS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_up,
  input  logic                step_dn,
  output logic [CNT_W-1:0]    count,
  output logic [SECTIONS-1:0] sec_en,
  output logic                at_top,
  output logic                at_bot
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(SECTIONS);

  always_ff @(posedge clk) begin
    if (rst)                  count <= '0;
    else if (step_up && !at_top) count <= count + 1'b1;
    else if (step_dn && !at_bot) count <= count - 1'b1;
  end

  assign at_top = (count == TOP);
  assign at_bot = (count == '0);

  for (genvar i = 0; i < SECTIONS; i++) begin : g_sec
    assign sec_en[i] = (count > CNT_W'(i));
  end
endmodule

// File: rtl/cap_step_ctrl.sv
module cap_step_ctrl
  import cap_step_pkg::*;
#(
  parameter int SECTIONS  = 9,
  parameter int ANGLE_W   = 12,
  parameter int UPPER_REF = 182,
  parameter int LOWER_REF = 141,
  parameter int SETTLE_W  = 8,
  parameter int CNT_W     = $clog2(SECTIONS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ang_valid,
  output logic                ang_ready,
  input  logic [ANGLE_W-1:0]  angle,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic [CNT_W-1:0]    sec_count,
  output logic [SECTIONS-1:0] sec_en,
  output logic                settle_busy,
  output logic                limit_hit
);
  dec_e dec;
  logic accept, decide_now, want_up, want_dn, do_up, do_dn;
  logic at_top, at_bot;

  assign ang_ready  = ~rst;
  assign accept     = ang_valid & ang_ready;
  assign decide_now = accept & ~settle_busy;
  assign want_up    = decide_now & (dec == DEC_UP);
  assign want_dn    = decide_now & (dec == DEC_DOWN);
  assign do_up      = want_up & ~at_top;
  assign do_dn      = want_dn & ~at_bot;

  cbk_decide #(
    .ANGLE_W(ANGLE_W), .UPPER_REF(UPPER_REF), .LOWER_REF(LOWER_REF)
  ) u_decide (
    .angle(angle), .dec(dec)
  );

  cbk_settle #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk(clk), .rst(rst), .load(do_up | do_dn), .load_val(settle_len),
    .tick(accept), .busy(settle_busy)
  );

  cbk_bank #(.SECTIONS(SECTIONS), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .step_up(do_up), .step_dn(do_dn),
    .count(sec_count), .sec_en(sec_en), .at_top(at_top), .at_bot(at_bot)
  );

  always_ff @(posedge clk) begin
    if (rst) limit_hit <= 1'b0;
    else     limit_hit <= (want_up & at_top) | (want_dn & at_bot);
  end
endmodule

// File: rtl/cap_step_ctrl_chk.sv
module cap_step_ctrl_chk #(
  parameter int SECTIONS  = 9,
  parameter int ANGLE_W   = 12,
  parameter int UPPER_REF = 182,
  parameter int LOWER_REF = 141,
  parameter int SETTLE_W  = 8,
  parameter int CNT_W     = $clog2(SECTIONS + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                ang_valid,
  input logic                ang_ready,
  input logic [ANGLE_W-1:0]  angle,
  input logic [SETTLE_W-1:0] settle_len,
  input logic [CNT_W-1:0]    sec_count,
  input logic [SECTIONS-1:0] sec_en,
  input logic                settle_busy,
  input logic                limit_hit
);
  localparam logic [CNT_W-1:0]   TOP = CNT_W'(SECTIONS);
  localparam logic [ANGLE_W-1:0] UPL = ANGLE_W'(UPPER_REF);
  localparam logic [ANGLE_W-1:0] LOL = ANGLE_W'(LOWER_REF);

  logic acc;
  logic [SECTIONS-1:0] en_plus1;
  assign acc      = ang_valid & ang_ready;
  assign en_plus1 = sec_en + 1'b1;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sec_count == '0 && !limit_hit && !settle_busy));

  assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && !settle_busy && angle > UPL && sec_count < TOP)
      |=> sec_count == $past(sec_count) + 1'b1);

  assert_step_dn_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && !settle_busy && angle < LOL && sec_count != '0)
      |=> sec_count == $past(sec_count) - 1'b1);

  assert_in_band_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && angle <= UPL && angle >= LOL) |=> $stable(sec_count));

  assert_top_limit_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && !settle_busy && angle > UPL && sec_count == TOP)
      |=> (sec_count == TOP && limit_hit));

  assert_thermo_R6: assert property (@(posedge clk) disable iff (rst)
    ((sec_en & en_plus1) == '0) && ($countones(sec_en) == int'(sec_count)));

  assert_settle_block_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && settle_busy) |=> $stable(sec_count));

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!ang_valid) |=> $stable(sec_count) && ($past(settle_busy) == settle_busy));

  assert_one_step_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sec_count) |-> ($past(acc) &&
      (sec_count == $past(sec_count) + 1'b1 || sec_count == $past(sec_count) - 1'b1)));

  assert_ready_R10: assert property (@(posedge clk) !rst |-> ang_ready);
endmodule

bind cap_step_ctrl cap_step_ctrl_chk #(
  .SECTIONS(SECTIONS), .ANGLE_W(ANGLE_W), .UPPER_REF(UPPER_REF),
  .LOWER_REF(LOWER_REF), .SETTLE_W(SETTLE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .ang_valid(ang_valid), .ang_ready(ang_ready),
  .angle(angle), .settle_len(settle_len), .sec_count(sec_count),
  .sec_en(sec_en), .settle_busy(settle_busy), .limit_hit(limit_hit)
);

// File: tb/tb_cap_step_ctrl.sv
module tb_cap_step_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SECTIONS = 9;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ang_valid = 1'b0;
  logic ang_ready;
  logic [11:0] angle = '0;
  logic [7:0] settle_len = '0;
  logic [CNT_W-1:0] sec_count;
  logic [SECTIONS-1:0] sec_en;
  logic settle_busy, limit_hit;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  int m_settle = 0;
  bit m_lim = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_step_ctrl dut (
    .clk(clk), .rst(rst), .ang_valid(ang_valid), .ang_ready(ang_ready),
    .angle(angle), .settle_len(settle_len), .sec_count(sec_count),
    .sec_en(sec_en), .settle_busy(settle_busy), .limit_hit(limit_hit)
  );

  function automatic logic [SECTIONS-1:0] thermo(int n);
    return SECTIONS'((1 << n) - 1);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench model of one clock edge (R2..R5, R7, R8)
  task automatic model_edge(bit v, int a, int sl);
    m_lim = 0;
    if (!v) return;
    if (m_settle > 0) begin
      m_settle--;
    end else if (a > 182) begin
      if (m_cnt < SECTIONS) begin m_cnt++; m_settle = sl; end
      else m_lim = 1;
    end else if (a < 141) begin
      if (m_cnt > 0) begin m_cnt--; m_settle = sl; end
      else m_lim = 1;
    end
  endtask

  task automatic send(bit v, int a, int sl, string req);
    @(negedge clk);
    ang_valid = v; angle = 12'(a); settle_len = 8'(sl);
    @(posedge clk);
    model_edge(v, a, sl);
    #(CLK_PERIOD/4);
    check({req, " count"}, int'(sec_count), m_cnt);
    check("R6 sec_en", int'(sec_en), int'(thermo(m_cnt)));
    check({req, " limit"}, int'(limit_hit), int'(m_lim));
    check("R7 busy", int'(settle_busy), int'(m_settle > 0));
    check("R10 ready", int'(ang_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 count", int'(sec_count), 0);
    check("R1 en", int'(sec_en), 0);
    check("R1 busy", int'(settle_busy), 0);
    check("R1 limit", int'(limit_hit), 0);
    check("R10 ready low in reset", int'(ang_ready), 0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < SECTIONS; i++) send(1, 250, 0, "R2");
    send(1, 300, 0, "R5 top");
    send(0, 300, 0, "R8 idle");
    send(1, 182, 0, "R4 upper edge");
    send(1, 141, 0, "R4 lower edge");
    send(1, 160, 0, "R4 mid");
    for (int i = 0; i < SECTIONS; i++) send(1, 50, 0, "R3");
    send(1, 0, 0, "R5 bottom");
    send(1, 140, 0, "R5 bottom again");
    // settle window of 2 with idle gaps
    send(1, 200, 2, "R2 load settle");
    send(0, 200, 0, "R8 idle in settle");
    send(1, 200, 0, "R7 blocked 1");
    send(1, 10, 0, "R7 blocked 2");
    send(1, 200, 0, "R7 free again");

    for (int i = 0; i < 2000; i++) begin
      int r = int'($urandom_range(0, 9));
      int a = (r < 4) ? int'($urandom_range(183, 400)) :
              (r < 8) ? int'($urandom_range(0, 140)) :
                        int'($urandom_range(141, 182));
      send(($urandom_range(0, 4) != 0), a, int'($urandom_range(0, 3)), "R9 random");
    end

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R1 reset after run", int'(sec_count), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule